// File: doc/BRIEF.md
# Serial Transmit Byte Queue with Threshold Flag and Handshake

This block sits on the transmit side of a buffered asynchronous serial port. It stands between the register interface of a processor and the shift stage that serialises the bytes. The processor pushes bytes into a 16-entry queue. The shift stage takes them out in order through a valid/ready pop port. The block reports the fill level and a "transmit space available" flag. The flag is raised whenever the number of stored bytes is at or below a threshold selected by a 2-bit code.

A held flush control empties the queue at once. An optional clear-to-send / request-to-send handshake is switched by an enable input. When the handshake is off, the incoming clear-to-send pin is ignored and the outgoing request line is held low. When it is on, a high clear-to-send input stops new bytes from being offered after a two-flop synchronizer. A byte that the shifter has already taken still finishes. Request-to-send then goes high for as long as the flush control is held. A write that finds the queue full is discarded and latches a sticky overflow bit until software clears it.

Top module: `sertx_queue`

## Requirements
- R1: Bytes leave on the pop port in the order they were written. `level` gives the number of stored bytes, up to 16, and updates at the clock edge that accepts a write or completes a pop (`pop_valid && pop_ready`). `pop_data` shows the oldest byte whenever `pop_valid` is 1.
- R2: A write while the queue holds 16 bytes and no pop completes in the same cycle is discarded. It sets `overflow` from the next edge on. `overflow` stays set until a cycle with `overflow_clr` = 1 and no new discarded write. A new discard takes priority over the clear.
- R3: `space_flag` is registered and updates at the same edge as `level`. It is 1 exactly when `level` is at or below the threshold selected by `trig_sel`: 2'b00 gives 8, 2'b01 gives 4, 2'b10 gives 2, and 2'b11 gives 0, so 2'b11 flags only an empty queue.
- R4: While `flush` = 1, `pop_valid` is 0 and writes are ignored without touching `overflow`. The queue is empty (`level` = 0, `space_flag` = 1) from the first edge on which `flush` is sampled as 1.
- R5: After synchronous reset, `level` = 0, `space_flag` = 1, `rts_n` = 0, `overflow` = 0 and `pop_valid` = 0.
- R6: With `flow_en` = 0, `cts_n` has no effect: `pop_valid` is 1 whenever the queue is non-empty and `flush` = 0. `rts_n` is 0 from the next edge on.
- R7: With `flow_en` = 1 and the synchronized `cts_n` high, `pop_valid` is 0 and the queue keeps its contents.
- R8: With `flow_en` = 1, `rts_n` is registered and equals the previous cycle's `flush`. It is high while a flush is held and low otherwise.
- R9: `cts_n` passes through two flip-flops that reset to 1. A change on the pin reaches `pop_valid` after the second rising edge following the change.
- R10: A write to a full queue in a cycle that also completes a pop is accepted. `level` stays 16 and `overflow` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the processor |
| wr_data | input | 8 | Byte to enqueue |
| trig_sel | input | 2 | Threshold code for the space flag |
| flow_en | input | 1 | Enables the clear-to-send / request-to-send handshake |
| flush | input | 1 | Held high to empty the queue |
| overflow_clr | input | 1 | Clears the sticky overflow bit |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| pop_ready | input | 1 | Shift stage accepts a byte |
| pop_valid | output | 1 | A byte is offered to the shift stage |
| pop_data | output | 8 | Oldest stored byte |
| space_flag | output | 1 | Stored-byte count at or below threshold |
| rts_n | output | 1 | Request-to-send, active low |
| level | output | 5 | Number of stored bytes |
| overflow | output | 1 | Sticky discarded-write indicator |

## Verification
A write and a pop can land in the same cycle, and the hard case is a queue that is already full. The bench keeps the queue at 16 bytes and writes with `pop_ready` high, so each edge completes a pop and offers a new byte together. Each such edge is judged three ways: `level` must stay at 16, `overflow` must stay clear, and the scoreboard must still see every byte in order. A second collision, a held flush arriving with a write and a pop, is judged by an empty queue and an unchanged `overflow`.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Threshold (in stored bytes) selected by the 2-bit code, scaled to depth.
  function automatic int unsigned trig_level(input logic [1:0] code,
                                             input int unsigned depth);
    case (code)
      2'b00:   return depth / 2;
      2'b01:   return depth / 4;
      2'b10:   return depth / 8;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sertx_sync.sv
module sertx_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RESET_VAL;
        else     chain_q <= d_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/sertx_store.sv
module sertx_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_nx
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;

  // Storage array without reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wdata;
  end

  always_comb begin
    count_nx = count_q;
    if (flush)
      count_nx = '0;
    else if (push && !pop)
      count_nx = count_q + 1'b1;
    else if (pop && !push)
      count_nx = count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_nx;
  end

  assign rdata = mem[rd_ptr_q];
  assign count = count_q;

  // R1: level never exceeds the capacity
  assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  // R2: the control logic never pushes into a full store without a pop
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (count_q == CNT_W'(DEPTH) && !pop) |-> !push);

  // R1: no pop from an empty store
  assert_no_underflow_R1: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0) |-> !pop);

  // R4: a sampled flush leaves the store empty
  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count_q == '0));
endmodule

// File: rtl/sertx_status.sv
module sertx_status #(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_nx,
  input  logic [1:0]       trig_sel,
  input  logic             drop,
  input  logic             clr,
  output logic             flag,
  output logic             ovf
);
  logic [CNT_W-1:0] thr;
  logic             flag_q, ovf_q;

  assign thr = CNT_W'(sertx_pkg::trig_level(trig_sel, DEPTH));

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b1;
    else     flag_q <= (count_nx <= thr);
  end

  always_ff @(posedge clk) begin
    if (rst)       ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
    else if (clr)  ovf_q <= 1'b0;
  end

  assign flag = flag_q;
  assign ovf  = ovf_q;

  // R2: overflow only rises after a discarded write
  assert_ovf_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(drop));

  // R2: overflow is sticky until cleared
  assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr) |=> ovf_q);
endmodule

// File: rtl/sertx_queue.sv
module sertx_queue #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        trig_sel,
  input  logic              flow_en,
  input  logic              flush,
  input  logic              overflow_clr,
  input  logic              cts_n,
  input  logic              pop_ready,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              space_flag,
  output logic              rts_n,
  output logic [CNT_W-1:0]  level,
  output logic              overflow
);
  logic             cts_s;
  logic             cts_ok;
  logic             do_pop, accept, drop;
  logic [CNT_W-1:0] count, count_nx;
  logic             rts_q;

  sertx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_cts_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (cts_n),
    .d_out (cts_s)
  );

  // With handshake off the pin is treated as permanently asserted.
  assign cts_ok    = !flow_en || !cts_s;
  assign pop_valid = (count != '0) && !flush && cts_ok;
  assign do_pop    = pop_valid && pop_ready;
  assign accept    = wr_en && !flush && ((count != CNT_W'(DEPTH)) || do_pop);
  assign drop      = wr_en && !flush && !accept;

  sertx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .push     (accept),
    .pop      (do_pop),
    .wdata    (wr_data),
    .rdata    (pop_data),
    .count    (count),
    .count_nx (count_nx)
  );

  sertx_status #(.DEPTH(DEPTH)) i_status (
    .clk      (clk),
    .rst      (rst),
    .count_nx (count_nx),
    .trig_sel (trig_sel),
    .drop     (drop),
    .clr      (overflow_clr),
    .flag     (space_flag),
    .ovf      (overflow)
  );

  always_ff @(posedge clk) begin
    if (rst) rts_q <= 1'b0;
    else     rts_q <= flow_en && flush;
  end

  assign rts_n = rts_q;
  assign level = count;

  // R3: with a steady code, the flag matches the level against the threshold
  assert_flag_level_R3: assert property (@(posedge clk) disable iff (rst)
    $stable(trig_sel) |-> (space_flag ==
      (count <= CNT_W'(sertx_pkg::trig_level(trig_sel, DEPTH)))));

  // R6: handshake disabled holds request-to-send low
  assert_rts_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !flow_en |=> !rts_n);

  // R6: handshake disabled never blocks a non-empty queue
  assert_no_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (!flow_en && !flush && count != '0) |-> pop_valid);

  // R7: a stalled queue keeps its contents
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (flow_en && cts_s && !flush && !wr_en) |=> $stable(count));
endmodule

// File: tb/test_sertx_queue.sv
module test_sertx_queue;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] trig_sel = 2'b00;
  logic       flow_en = 1'b0, flush = 1'b0, overflow_clr = 1'b0;
  logic       cts_n = 1'b0, pop_ready = 1'b0;
  logic       pop_valid, space_flag, rts_n, overflow;
  logic [7:0] pop_data;
  logic [4:0] level;

  int n_checks = 0, n_fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] sb[$];
  bit m_s1 = 1'b1, m_s2 = 1'b1, m_ovf = 1'b0, m_rts = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sertx_queue i_sertx_queue (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .trig_sel(trig_sel), .flow_en(flow_en), .flush(flush),
    .overflow_clr(overflow_clr), .cts_n(cts_n), .pop_ready(pop_ready),
    .pop_valid(pop_valid), .pop_data(pop_data), .space_flag(space_flag),
    .rts_n(rts_n), .level(level), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int thr_of(input logic [1:0] c);
    case (c)
      2'b00: return 8;
      2'b01: return 4;
      2'b10: return 2;
      default: return 0;
    endcase
  endfunction

  // Driver plus scoreboard: one clock cycle with given write/ready.
  task automatic step(input bit wr, input logic [7:0] d, input bit rdy);
    bit cts_ok, exp_valid, pop, acc, drp, full_collide;
    string vtag;
    @(negedge clk);
    wr_en = wr; wr_data = d; pop_ready = rdy;
    #1;
    cts_ok    = !flow_en || !m_s2;
    exp_valid = (sb.size() > 0) && cts_ok && !flush;
    if (flush) vtag = "R4";
    else if (flow_en && (m_s2 != m_s1)) vtag = "R9";
    else if (flow_en && m_s2) vtag = "R7";
    else if (!flow_en && cts_n) vtag = "R6";
    else vtag = "R1";
    chk(pop_valid == exp_valid, {vtag, " pop_valid"}, pop_valid, exp_valid);
    if (exp_valid && pop_valid)
      chk(pop_data == sb[0], "R1 pop_data order", pop_data, sb[0]);
    pop = exp_valid && rdy;
    full_collide = wr && !flush && sb.size() == 16 && pop;
    acc = wr && !flush && (sb.size() < 16 || pop);
    drp = wr && !flush && !acc;
    @(posedge clk);
    if (flush) sb.delete();
    else begin
      if (pop) void'(sb.pop_front());
      if (acc) sb.push_back(d);
    end
    if (drp) m_ovf = 1'b1;
    else if (overflow_clr) m_ovf = 1'b0;
    m_rts = flow_en && flush;
    m_s2 = m_s1; m_s1 = cts_n;
    #1;
    chk(level == sb.size(), full_collide ? "R10 level" : "R1 level", level, sb.size());
    chk(space_flag == (sb.size() <= thr_of(trig_sel)), "R3 space_flag",
        space_flag, sb.size() <= thr_of(trig_sel));
    chk(overflow == m_ovf, full_collide ? "R10 overflow" : "R2 overflow", overflow, m_ovf);
    chk(rts_n == m_rts, flow_en ? "R8 rts_n" : "R6 rts_n", rts_n, m_rts);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R5: reset state
    chk(level == 0, "R5 level", level, 0);
    chk(space_flag == 1'b1, "R5 space_flag", space_flag, 1);
    chk(rts_n == 1'b0, "R5 rts_n", rts_n, 0);
    chk(overflow == 1'b0, "R5 overflow", overflow, 0);
    chk(pop_valid == 1'b0, "R5 pop_valid", pop_valid, 0);

    // Basic fill and drain, code 00
    for (int i = 0; i < 12; i++) step(1'b1, 8'(i + 8'h30), 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, 8'h00, 1'b1);

    // All four threshold codes, with overflow on each full queue (R2, R3)
    for (int t = 0; t < 4; t++) begin
      trig_sel = 2'(t);
      for (int i = 0; i < 18; i++) step(1'b1, 8'(t * 32 + i), 1'b0);
      overflow_clr = 1'b1; step(1'b0, 8'h00, 1'b0); overflow_clr = 1'b0;
      for (int i = 0; i < 16; i++) step(1'b0, 8'h00, 1'b1);
    end

    // Write and pop together on a full queue (R10)
    trig_sel = 2'b01;
    for (int i = 0; i < 16; i++) step(1'b1, 8'(8'hA0 + i), 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 8'(8'hC0 + i), 1'b1);
    for (int i = 0; i < 17; i++) step(1'b0, 8'h00, 1'b1);

    // Flush mid-stream with handshake enabled (R4, R8)
    flow_en = 1'b1; cts_n = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'h50 + i), 1'b0);
    step(1'b0, 8'h00, 1'b1);
    flush = 1'b1;
    step(1'b1, 8'hEE, 1'b1);
    step(1'b1, 8'hEF, 1'b1);
    flush = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, 8'(8'h60 + i), 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1);

    // Handshake off: pin ignored (R6)
    flow_en = 1'b0; cts_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 8'(8'h70 + i), 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b1);

    // Handshake on: stall, then release through the synchronizer (R7, R9)
    flow_en = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 8'(8'h80 + i), 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1);
    cts_n = 1'b0;
    for (int i = 0; i < 7; i++) step(1'b0, 8'h00, 1'b1);
    step(1'b1, 8'h91, 1'b0);
    cts_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1);
    cts_n = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1);

    // Mixed traffic
    flow_en = 1'b0; trig_sel = 2'b10;
    for (int i = 0; i < 60; i++) step((i % 3) != 2, 8'(i * 7), (i % 2) == 0);
    for (int i = 0; i < 20; i++) step(1'b0, 8'h00, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule